// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an operand access request of a 16-bit-accumulator, 24-bit-address processor core into a bus address. It also returns the follow-on program counter and stack pointer. Each request carries a 4-bit access-mode code, a 24-bit operand offset, and the current bank, program counter, direct page, stack pointer and emulation-flag values. Each mode has its own wrap rule. Some addresses may carry into the bank byte. Others are held to a 16-bit window in bank 0. Others wrap within a single 256-byte page.

Stack pulls increment the stack pointer before the access, and pushes decrement it after the access. When the emulation flag is set, the standard stack modes change only the low byte of the stack pointer. A second pair of stack modes always adjusts all 16 bits.

All results are registered. They appear one clock after a request, together with a single-cycle update strobe that tells the register file to load the new program counter and stack pointer. Opcode decode, bus timing and the registers themselves live outside this block.

Top module: `eag_core`

## Requirements
- R1: Mode 0 (program fetch) gives address {pbank_i, pc_i} and next PC = pc_i + 1 modulo 2^16; the bank byte never changes. Every other mode returns pc_next_o = pc_i.
- R2: Mode 1 (data bank) gives address ({dbank_i, 16'h0000} + offset_i) modulo 2^24, so a carry moves into the bank byte.
- R3: Mode 2 (program bank) gives address {pbank_i, offset_i[15:0]} with no carry into the bank.
- R4: Mode 3 (direct page) gives {8'h00, dpage_i[15:8], (dpage_i + offset_i)[7:0]} when emu_i = 1 and dpage_i[7:0] = 0. In every other case it gives {8'h00, (dpage_i + offset_i[15:0]) mod 2^16}.
- R5: Mode 4 (stack relative) gives {8'h00, (sp_i + offset_i[15:0]) mod 2^16}.
- R6: Mode 5 (pull) increments S first and addresses {8'h00, new S}. With emu_i = 1 only S[7:0] increments and wraps, and S[15:8] is kept. With emu_i = 0 all 16 bits increment.
- R7: Mode 6 (push) addresses {8'h00, sp_i} and then decrements S. With emu_i = 1 only the low byte changes; with emu_i = 0 all 16 bits change.
- R8: Modes 7 (full pull) and 8 (full push) behave as modes 5 and 6 with a 16-bit adjust, regardless of emu_i. Every mode other than 5 to 8 returns sp_next_o = sp_i.
- R9: Mode 9 (absolute) gives {8'h00, offset_i[15:0]}, and mode 10 (long) gives offset_i[23:0].
- R10: A request with a defined mode (0 to 10) updates addr_o, pc_next_o and sp_next_o on the next rising edge and raises upd_o for exactly that one cycle. Without a request the outputs hold and upd_o stays low.
- R11: A request with an undefined mode code (11 to 15) is ignored: upd_o stays low and all outputs keep their previous values.
- R12: While rst_ni is low, addr_o, pc_next_o and sp_next_o are zero and upd_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| mode_i | input | 4 | Access-mode code |
| offset_i | input | 24 | Operand offset |
| dbank_i | input | 8 | Data bank |
| pbank_i | input | 8 | Program bank |
| pc_i | input | 16 | Program counter |
| dpage_i | input | 16 | Direct page base |
| sp_i | input | 16 | Stack pointer |
| emu_i | input | 1 | Emulation flag |
| addr_o | output | 24 | Registered bus address |
| pc_next_o | output | 16 | Registered next program counter |
| sp_next_o | output | 16 | Registered next stack pointer |
| upd_o | output | 1 | One-cycle strobe marking new results |

## Verification
Every result is registered once, so addr_o, pc_next_o, sp_next_o and upd_o are all due one rising edge after the edge that samples req_i. The bench drives a request on a falling edge and drops req_i on the next falling edge. It compares all four outputs at that second falling edge, half a period after they were loaded. For the strobe-width checks and the hold checks on idle cycles and undefined codes, the bench samples one and two further falling edges later, when a wrong update would already be visible.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    MODE_FETCH     = 4'd0,
    MODE_DBANK     = 4'd1,
    MODE_PBANK     = 4'd2,
    MODE_DPAGE     = 4'd3,
    MODE_SREL      = 4'd4,
    MODE_PULL      = 4'd5,
    MODE_PUSH      = 4'd6,
    MODE_PULL_FULL = 4'd7,
    MODE_PUSH_FULL = 4'd8,
    MODE_ABS       = 4'd9,
    MODE_LONG      = 4'd10
  } eag_mode_e;

  localparam int unsigned MODE_LAST = 10;
endpackage

// File: rtl/eag_stack_unit.sv
module eag_stack_unit #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [3:0]        mode_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic              emu_i,
  output logic [WORD_W-1:0] sp_next_o,
  output logic [WORD_W-1:0] sp_addr_o
);
  import eag_pkg::*;

  logic [WORD_W-1:0] inc_full, dec_full, inc_page, dec_page;
  logic [PAGE_W-1:0] lo_inc, lo_dec;

  assign inc_full = sp_i + 1'b1;
  assign dec_full = sp_i - 1'b1;
  assign lo_inc   = sp_i[PAGE_W-1:0] + 1'b1;
  assign lo_dec   = sp_i[PAGE_W-1:0] - 1'b1;
  assign inc_page = {sp_i[WORD_W-1:PAGE_W], lo_inc};
  assign dec_page = {sp_i[WORD_W-1:PAGE_W], lo_dec};

  always_comb begin
    sp_next_o = sp_i;
    sp_addr_o = sp_i;
    unique case (mode_i)
      MODE_PULL: begin
        sp_next_o = emu_i ? inc_page : inc_full;
        sp_addr_o = sp_next_o;  // pre-increment
      end
      MODE_PUSH:      sp_next_o = emu_i ? dec_page : dec_full;
      MODE_PULL_FULL: begin
        sp_next_o = inc_full;
        sp_addr_o = inc_full;
      end
      MODE_PUSH_FULL: sp_next_o = dec_full;
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_dpage_unit.sv
module eag_dpage_unit #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAGE_W = 8
) (
  input  logic [WORD_W-1:0] dpage_i,
  input  logic [WORD_W-1:0] off_i,
  input  logic              emu_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sum;
  logic              page_lock;

  assign sum       = dpage_i + off_i;
  assign page_lock = emu_i && (dpage_i[PAGE_W-1:0] == '0);
  assign word_o    = page_lock ? {dpage_i[WORD_W-1:PAGE_W], sum[PAGE_W-1:0]} : sum;
endmodule

// File: rtl/eag_addr_sel.sv
module eag_addr_sel #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned ADDR_W = BANK_W + WORD_W
) (
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [BANK_W-1:0] dbank_i,
  input  logic [BANK_W-1:0] pbank_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] dpage_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic              emu_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] pc_next_o,
  output logic [WORD_W-1:0] sp_next_o,
  output logic              valid_o
);
  import eag_pkg::*;

  localparam logic [BANK_W-1:0] BANK0 = '0;

  logic [WORD_W-1:0] dp_word, sp_addr, srel_word;
  logic [ADDR_W-1:0] dbank_sum;

  eag_dpage_unit #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) i_dpage (
    .dpage_i (dpage_i),
    .off_i   (offset_i[WORD_W-1:0]),
    .emu_i   (emu_i),
    .word_o  (dp_word)
  );

  eag_stack_unit #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) i_stack (
    .mode_i    (mode_i),
    .sp_i      (sp_i),
    .emu_i     (emu_i),
    .sp_next_o (sp_next_o),
    .sp_addr_o (sp_addr)
  );

  assign srel_word = sp_i + offset_i[WORD_W-1:0];
  assign dbank_sum = {dbank_i, {WORD_W{1'b0}}} + offset_i;
  assign valid_o   = (mode_i <= 4'(MODE_LAST));

  always_comb begin
    pc_next_o = pc_i;
    addr_o    = '0;
    unique case (mode_i)
      MODE_FETCH: begin
        addr_o    = {pbank_i, pc_i};
        pc_next_o = pc_i + 1'b1;
      end
      MODE_DBANK:     addr_o = dbank_sum;
      MODE_PBANK:     addr_o = {pbank_i, offset_i[WORD_W-1:0]};
      MODE_DPAGE:     addr_o = {BANK0, dp_word};
      MODE_SREL:      addr_o = {BANK0, srel_word};
      MODE_PULL, MODE_PUSH,
      MODE_PULL_FULL, MODE_PUSH_FULL:
                      addr_o = {BANK0, sp_addr};
      MODE_ABS:       addr_o = {BANK0, offset_i[WORD_W-1:0]};
      MODE_LONG:      addr_o = offset_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_core.sv
module eag_core #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAGE_W = 8,
  localparam int unsigned ADDR_W = BANK_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        mode_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [BANK_W-1:0] dbank_i,
  input  logic [BANK_W-1:0] pbank_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] dpage_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic              emu_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] pc_next_o,
  output logic [WORD_W-1:0] sp_next_o,
  output logic              upd_o
);
  logic [ADDR_W-1:0] addr_c;
  logic [WORD_W-1:0] pc_c, sp_c;
  logic              valid_c, load;

  eag_addr_sel #(.BANK_W(BANK_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) i_sel (
    .mode_i    (mode_i),
    .offset_i  (offset_i),
    .dbank_i   (dbank_i),
    .pbank_i   (pbank_i),
    .pc_i      (pc_i),
    .dpage_i   (dpage_i),
    .sp_i      (sp_i),
    .emu_i     (emu_i),
    .addr_o    (addr_c),
    .pc_next_o (pc_c),
    .sp_next_o (sp_c),
    .valid_o   (valid_c)
  );

  assign load = req_i && valid_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      pc_next_o <= '0;
      sp_next_o <= '0;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= load;
      if (load) begin
        addr_o    <= addr_c;
        pc_next_o <= pc_c;
        sp_next_o <= sp_c;
      end
    end
  end
endmodule

// File: rtl/eag_core_chk.sv
module eag_core_chk #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned ADDR_W = BANK_W + WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [3:0]        mode_i,
  input logic [BANK_W-1:0] pbank_i,
  input logic [WORD_W-1:0] sp_i,
  input logic              emu_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [WORD_W-1:0] sp_next_o,
  input logic              upd_o
);
  AST_UPD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i <= 4'd10) |=> upd_o);  // R10

  AST_UNUSED_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i > 4'd10) |=> !upd_o);  // R11

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(addr_o) && $stable(sp_next_o)));  // R10

  AST_FETCH_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 4'd0) |=> addr_o[ADDR_W-1:WORD_W] == $past(pbank_i));  // R1

  AST_DPAGE_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 4'd3) |=> addr_o[ADDR_W-1:WORD_W] == '0);  // R4

  AST_EMU_SP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && emu_i && (mode_i == 4'd5 || mode_i == 4'd6))
      |=> sp_next_o[WORD_W-1:8] == $past(sp_i[WORD_W-1:8]));  // R6

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!upd_o && addr_o == '0));  // R12
endmodule

bind eag_core eag_core_chk #(.BANK_W(BANK_W), .WORD_W(WORD_W)) i_eag_core_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mode_i    (mode_i),
  .pbank_i   (pbank_i),
  .sp_i      (sp_i),
  .emu_i     (emu_i),
  .addr_o    (addr_o),
  .sp_next_o (sp_next_o),
  .upd_o     (upd_o)
);

// File: tb/test_eag_core.sv
module test_eag_core;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 27;

  typedef struct packed {
    logic [3:0]  rq;
    logic [3:0]  mode;
    logic [23:0] off;
    logic [7:0]  db;
    logic [7:0]  pb;
    logic [15:0] pc;
    logic [15:0] dp;
    logic [15:0] sp;
    logic        emu;
    logic [23:0] e_addr;
    logic [15:0] e_pc;
    logic [15:0] e_sp;
  } vec_t;

  // rq, mode, off, db, pb, pc, dp, sp, emu, exp addr, exp pc, exp sp
  localparam vec_t VEC [NVEC] = '{
    '{4'd1, 4'd0,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h128000, 16'h8001, 16'h01FF}, // R1
    '{4'd1, 4'd0,  24'h000000, 8'h7E, 8'h12, 16'hFFFF, 16'h0000, 16'h01FF, 1'b1, 24'h12FFFF, 16'h0000, 16'h01FF}, // R1 pc wrap
    '{4'd2, 4'd1,  24'h001234, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h7E1234, 16'h8000, 16'h01FF}, // R2
    '{4'd2, 4'd1,  24'h018000, 8'h7F, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h808000, 16'h8000, 16'h01FF}, // R2 carry
    '{4'd2, 4'd1,  24'h010000, 8'hFF, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h000000, 16'h8000, 16'h01FF}, // R2 24-bit wrap
    '{4'd3, 4'd2,  24'hAB5678, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h125678, 16'h8000, 16'h01FF}, // R3
    '{4'd3, 4'd2,  24'h00FFFF, 8'h7E, 8'h34, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h34FFFF, 16'h8000, 16'h01FF}, // R3
    '{4'd4, 4'd3,  24'h0000FF, 8'h7E, 8'h12, 16'h8000, 16'h2000, 16'h01FF, 1'b1, 24'h0020FF, 16'h8000, 16'h01FF}, // R4
    '{4'd4, 4'd3,  24'h000105, 8'h7E, 8'h12, 16'h8000, 16'h2000, 16'h01FF, 1'b1, 24'h002005, 16'h8000, 16'h01FF}, // R4 page wrap
    '{4'd4, 4'd3,  24'h000105, 8'h7E, 8'h12, 16'h8000, 16'h2000, 16'h01FF, 1'b0, 24'h002105, 16'h8000, 16'h01FF}, // R4 native
    '{4'd4, 4'd3,  24'h000020, 8'h7E, 8'h12, 16'h8000, 16'h20F0, 16'h01FF, 1'b1, 24'h002110, 16'h8000, 16'h01FF}, // R4 low byte set
    '{4'd4, 4'd3,  24'hAA0020, 8'h7E, 8'h12, 16'h8000, 16'hFFF0, 16'h01FF, 1'b0, 24'h000010, 16'h8000, 16'h01FF}, // R4 16-bit wrap
    '{4'd5, 4'd4,  24'h000010, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01F0, 1'b0, 24'h000200, 16'h8000, 16'h01F0}, // R5
    '{4'd5, 4'd4,  24'h050010, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'hFFF8, 1'b1, 24'h000008, 16'h8000, 16'hFFF8}, // R5 wrap
    '{4'd6, 4'd5,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b1, 24'h000100, 16'h8000, 16'h0100}, // R6 emu
    '{4'd6, 4'd5,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h000200, 16'h8000, 16'h0200}, // R6 native
    '{4'd6, 4'd5,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h1234, 1'b0, 24'h001235, 16'h8000, 16'h1235}, // R6
    '{4'd7, 4'd6,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h0100, 1'b1, 24'h000100, 16'h8000, 16'h01FF}, // R7 emu
    '{4'd7, 4'd6,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h0100, 1'b0, 24'h000100, 16'h8000, 16'h00FF}, // R7 native
    '{4'd8, 4'd7,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b1, 24'h000200, 16'h8000, 16'h0200}, // R8 full pull
    '{4'd8, 4'd8,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h0100, 1'b1, 24'h000100, 16'h8000, 16'h00FF}, // R8 full push
    '{4'd8, 4'd8,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h0000, 1'b0, 24'h000000, 16'h8000, 16'hFFFF}, // R8 wrap
    '{4'd8, 4'd7,  24'h000000, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'hFFFF, 1'b1, 24'h000000, 16'h8000, 16'h0000}, // R8 wrap
    '{4'd9, 4'd9,  24'hAB1234, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'h001234, 16'h8000, 16'h01FF}, // R9 abs
    '{4'd9, 4'd10, 24'hAB1234, 8'h7E, 8'h12, 16'h8000, 16'h0000, 16'h01FF, 1'b0, 24'hAB1234, 16'h8000, 16'h01FF}, // R9 long
    '{4'd9, 4'd10, 24'hFFFFFF, 8'h00, 8'h00, 16'h4321, 16'h0000, 16'h0055, 1'b1, 24'hFFFFFF, 16'h4321, 16'h0055}, // R9 long
    '{4'd1, 4'd0,  24'h123456, 8'h00, 8'hFF, 16'h00FF, 16'h0000, 16'h0155, 1'b1, 24'hFF00FF, 16'h0100, 16'h0155}  // R1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [23:0] offset_i = '0;
  logic [7:0]  dbank_i = '0, pbank_i = '0;
  logic [15:0] pc_i = '0, dpage_i = '0, sp_i = '0;
  logic        emu_i = 1'b0;
  logic [23:0] addr_o;
  logic [15:0] pc_next_o, sp_next_o;
  logic        upd_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  eag_core i_eag_core (
    .clk_i, .rst_ni, .req_i, .mode_i, .offset_i, .dbank_i, .pbank_i,
    .pc_i, .dpage_i, .sp_i, .emu_i, .addr_o, .pc_next_o, .sp_next_o, .upd_o
  );

  task automatic check(input string rq, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    req_i = 1'b1; mode_i = v.mode; offset_i = v.off; dbank_i = v.db; pbank_i = v.pb;
    pc_i = v.pc; dpage_i = v.dp; sp_i = v.sp; emu_i = v.emu;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    vec_t v;
    // R12: reset state
    #(CLK_PERIOD * 2 + 1);
    check("R12", "addr", addr_o, 24'h0);
    check("R12", "upd", {23'b0, upd_o}, 24'h0);
    check("R12", "sp", {8'h0, sp_next_o}, 24'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      apply(v);
      check(tag, "upd", {23'b0, upd_o}, 24'h1);
      check(tag, "addr", addr_o, v.e_addr);
      check(tag, "pc", {8'h0, pc_next_o}, {8'h0, v.e_pc});
      check(tag, "sp", {8'h0, sp_next_o}, {8'h0, v.e_sp});
    end

    // R10: strobe lasts one cycle, outputs hold while idle
    @(negedge clk_i);
    check("R10", "upd width", {23'b0, upd_o}, 24'h0);
    check("R10", "addr hold", addr_o, 24'hFF00FF);
    sp_i = 16'h7777; offset_i = 24'h333333; mode_i = 4'd10;
    @(negedge clk_i);
    check("R10", "addr idle", addr_o, 24'hFF00FF);
    check("R10", "sp idle", {8'h0, sp_next_o}, 24'h000155);

    // R11: undefined codes are ignored
    for (int m = 11; m < 16; m++) begin
      @(negedge clk_i);
      req_i = 1'b1; mode_i = 4'(m); offset_i = 24'h5A5A5A; pc_i = 16'h9999; sp_i = 16'h4444;
      @(negedge clk_i);
      req_i = 1'b0;
      check("R11", "upd", {23'b0, upd_o}, 24'h0);
      check("R11", "addr", addr_o, 24'hFF00FF);
      check("R11", "pc", {8'h0, pc_next_o}, 24'h000100);
      check("R11", "sp", {8'h0, sp_next_o}, 24'h000155);
    end

    // R12: asynchronous reset clears loaded results
    #(CLK_PERIOD / 4);
    rst_ni = 1'b0;
    #1;
    check("R12", "addr async", addr_o, 24'h0);
    check("R12", "pc async", {8'h0, pc_next_o}, 24'h0);
    finish_run();
  end
endmodule